// File: doc/BRIEF.md
# Program Event Recording Monitor

This block watches a processor's retirement stream for debug events. Two kinds of event are recorded: a taken branch and an instruction fetch. Each one is qualified against a programmable address window. The window is bounded by a start and an end address. Both bounds are inclusive, and when the start lies above the end the window wraps past the top of the address space. A four-bit control word selects which events are enabled, whether branches are filtered by their target address, and whether a fetch event nullifies the instruction at once.

A recorded event sets a pending record. The record holds an event code, the address of the instruction that caused the event, and that instruction's length. The exception logic later pulses a check strobe. If the record is non-empty, the block requests a program exception that carries the recorded length. A fetch event that is set to nullify requests the exception on its own, without waiting for the check. The exception logic acknowledges the exception it takes, and that acknowledge empties the record.

Top module: `pem_monitor`

## Requirements
- R1: While reset is low, and on the first sampled cycle after it, the pending code, pending address, pending length, nullify request, exception request and exception length are all zero.
- R2: With start <= end, an address hits the window exactly when start <= addr <= end, compared unsigned over the full address width.
- R3: With start > end, the window wraps, and an address hits exactly when addr >= start or addr <= end.
- R4: A branch strobe records nothing when control bit 0 (branch enable) is clear.
- R5: With control bit 2 (branch window filter) clear, every enabled branch qualifies. With it set, only branches whose to-address hits the window qualify.
- R6: A qualifying branch loads the record on the next clock edge. The code becomes 0x80 OR the 2-bit space identifier in code bits [1:0], the address becomes the from-address, and the length becomes the branch length.
- R7: A fetch qualifies only when control bit 1 (fetch enable) is set and the fetch address hits the window. It loads code 0x40 OR the space identifier, the fetch address and the fetch length. A non-zero pending code always has bit 7 or bit 6 set.
- R8: When control bit 3 (nullify) is set on a qualifying fetch, code bit 2 (0x04) is also set. In the cycle after the fetch, both the nullify request and the exception request are high, and the exception length equals the fetch length.
- R9: A check strobe raises the exception request in the next cycle exactly when the pending code is non-zero. The exception length is then the pending length. Without a check or a nullifying fetch, the exception request and the exception length are zero.
- R10: An acknowledge empties the record on the next edge. If a qualifying event arrives in the same cycle, the new event is loaded instead.
- R11: When a qualifying branch and a qualifying fetch arrive together, the fetch address and the fetch length are recorded, and the code is the OR of both codes.
- R12: A new qualifying event replaces any record that is already pending.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_word | input | 4 | Bit0 branch enable, bit1 fetch enable, bit2 branch window filter, bit3 nullify |
| win_lo | input | 64 | Window start address (inclusive) |
| win_hi | input | 64 | Window end address (inclusive) |
| space_id | input | 2 | Address-space identifier ORed into codes |
| br_vld | input | 1 | Taken-branch strobe |
| br_from | input | 64 | Address of the branch instruction |
| br_to | input | 64 | Branch target address |
| br_ilen | input | 2 | Length code of the branch instruction |
| fe_vld | input | 1 | Instruction-fetch strobe |
| fe_addr | input | 64 | Fetch address |
| fe_ilen | input | 2 | Length code of the fetched instruction |
| chk_vld | input | 1 | Pending-event check strobe |
| exc_ack | input | 1 | Exception taken; empties the record |
| pend_code | output | 8 | Pending event code |
| pend_addr | output | 64 | Latched event address |
| pend_ilen | output | 2 | Latched instruction length |
| nullify_req | output | 1 | Nullify the current instruction now |
| exc_req | output | 1 | Program exception request |
| exc_ilen | output | 2 | Length reported with the exception |

## Verification
Every result is registered exactly once. The record, the nullify request and the exception request therefore all reflect the strobes of the previous cycle, one clock edge after the stimulus. The bench applies inputs at the falling edge and advances a behavioural model of the same cycle. It then compares all six outputs at the next falling edge, so each comparison sees the register state just after the edge that consumed the stimulus. Reset is checked while it is still asserted, because it acts asynchronously.

// File: rtl/pem_pkg.sv
package pem_pkg;
  localparam int CTL_W  = 4;
  localparam int CODE_W = 8;
  localparam int SID_W  = 2;
  localparam int ILEN_W = 2;

  localparam int CTL_BR_EN  = 0;
  localparam int CTL_FE_EN  = 1;
  localparam int CTL_BR_WIN = 2;
  localparam int CTL_NULL   = 3;

  localparam logic [CODE_W-1:0] CODE_BR   = 8'h80;
  localparam logic [CODE_W-1:0] CODE_FE   = 8'h40;
  localparam logic [CODE_W-1:0] CODE_NULL = 8'h04;
  localparam logic [CODE_W-1:0] CODE_KIND = CODE_BR | CODE_FE;

  typedef struct packed {
    logic              vld;
    logic              nul;
    logic [CODE_W-1:0] code;
    logic [ILEN_W-1:0] ilen;
  } evt_hdr_t;
endpackage

// File: rtl/pem_win_match.sv
module pem_win_match #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic ge_lo, le_hi, wraps;

  always_comb begin
    ge_lo = (addr >= lo);
    le_hi = (addr <= hi);
    wraps = (lo > hi);
    hit   = wraps ? (ge_lo | le_hi) : (ge_lo & le_hi);
  end
endmodule

// File: rtl/pem_evt_select.sv
module pem_evt_select
  import pem_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [CTL_W-1:0]  ctl_word,
  input  logic [SID_W-1:0]  space_id,
  input  logic              br_vld,
  input  logic [ADDR_W-1:0] br_from,
  input  logic [ILEN_W-1:0] br_ilen,
  input  logic              br_to_hit,
  input  logic              fe_vld,
  input  logic [ADDR_W-1:0] fe_addr,
  input  logic [ILEN_W-1:0] fe_ilen,
  input  logic              fe_hit,
  output evt_hdr_t          evt,
  output logic [ADDR_W-1:0] evt_addr
);
  logic br_q, fe_q;
  logic [CODE_W-1:0] sid_bits;

  always_comb begin
    sid_bits = CODE_W'(space_id);
    br_q = br_vld & ctl_word[CTL_BR_EN] & (~ctl_word[CTL_BR_WIN] | br_to_hit);
    fe_q = fe_vld & ctl_word[CTL_FE_EN] & fe_hit;

    evt      = '0;
    evt_addr = '0;
    if (fe_q) begin
      evt.vld  = 1'b1;
      evt.nul  = ctl_word[CTL_NULL];
      evt.code = CODE_FE | sid_bits
               | (ctl_word[CTL_NULL] ? CODE_NULL : '0)
               | (br_q ? CODE_BR : '0);
      evt.ilen = fe_ilen;
      evt_addr = fe_addr;
    end else if (br_q) begin
      evt.vld  = 1'b1;
      evt.code = CODE_BR | sid_bits;
      evt.ilen = br_ilen;
      evt_addr = br_from;
    end
  end
endmodule

// File: rtl/pem_evt_record.sv
module pem_evt_record
  import pem_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  evt_hdr_t          evt,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic              chk_vld,
  input  logic              exc_ack,
  output logic [CODE_W-1:0] pend_code,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [ILEN_W-1:0] pend_ilen,
  output logic              nullify_req,
  output logic              exc_req,
  output logic [ILEN_W-1:0] exc_ilen
);
  logic              pend_en;
  logic [CODE_W-1:0] code_d;
  logic [ADDR_W-1:0] addr_d;
  logic [ILEN_W-1:0] ilen_d;
  logic              chk_hit;
  logic              null_d, exc_d;
  logic [ILEN_W-1:0] eilen_d;

  always_comb begin
    pend_en = evt.vld | exc_ack;
    code_d  = evt.vld ? evt.code : '0;
    addr_d  = evt.vld ? evt_addr : '0;
    ilen_d  = evt.vld ? evt.ilen : '0;
    chk_hit = chk_vld & (pend_code != '0);
    null_d  = evt.vld & evt.nul;
    exc_d   = null_d | chk_hit;
    if (null_d)       eilen_d = evt.ilen;
    else if (chk_hit) eilen_d = pend_ilen;
    else              eilen_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_code <= '0;
      pend_addr <= '0;
      pend_ilen <= '0;
    end else if (pend_en) begin
      pend_code <= code_d;
      pend_addr <= addr_d;
      pend_ilen <= ilen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nullify_req <= 1'b0;
      exc_req     <= 1'b0;
      exc_ilen    <= '0;
    end else begin
      nullify_req <= null_d;
      exc_req     <= exc_d;
      exc_ilen    <= eilen_d;
    end
  end

  AST_NULL_RAISES_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    nullify_req |-> exc_req); // R8
  AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_ack && !evt.vld) |=> (pend_code == '0)); // R10
  AST_CHK_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_vld && pend_code == '0 && !evt.vld) |=> !exc_req); // R9
  AST_CODE_HAS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_code != '0) |-> ((pend_code & CODE_KIND) != '0)); // R7
endmodule

// File: rtl/pem_monitor.sv
module pem_monitor
  import pem_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTL_W-1:0]  ctl_word,
  input  logic [ADDR_W-1:0] win_lo,
  input  logic [ADDR_W-1:0] win_hi,
  input  logic [SID_W-1:0]  space_id,
  input  logic              br_vld,
  input  logic [ADDR_W-1:0] br_from,
  input  logic [ADDR_W-1:0] br_to,
  input  logic [ILEN_W-1:0] br_ilen,
  input  logic              fe_vld,
  input  logic [ADDR_W-1:0] fe_addr,
  input  logic [ILEN_W-1:0] fe_ilen,
  input  logic              chk_vld,
  input  logic              exc_ack,
  output logic [CODE_W-1:0] pend_code,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [ILEN_W-1:0] pend_ilen,
  output logic              nullify_req,
  output logic              exc_req,
  output logic [ILEN_W-1:0] exc_ilen
);
  localparam int N_CMP = 2;

  logic [N_CMP-1:0][ADDR_W-1:0] cmp_addr;
  logic [N_CMP-1:0]             cmp_hit;
  evt_hdr_t                     evt;
  logic [ADDR_W-1:0]            evt_addr;

  assign cmp_addr[0] = br_to;
  assign cmp_addr[1] = fe_addr;

  for (genvar g = 0; g < N_CMP; g++) begin : g_win
    pem_win_match #(.ADDR_W(ADDR_W)) u_match (
      .lo   (win_lo),
      .hi   (win_hi),
      .addr (cmp_addr[g]),
      .hit  (cmp_hit[g])
    );
  end

  pem_evt_select #(.ADDR_W(ADDR_W)) u_sel (
    .ctl_word  (ctl_word),
    .space_id  (space_id),
    .br_vld    (br_vld),
    .br_from   (br_from),
    .br_ilen   (br_ilen),
    .br_to_hit (cmp_hit[0]),
    .fe_vld    (fe_vld),
    .fe_addr   (fe_addr),
    .fe_ilen   (fe_ilen),
    .fe_hit    (cmp_hit[1]),
    .evt       (evt),
    .evt_addr  (evt_addr)
  );

  pem_evt_record #(.ADDR_W(ADDR_W)) u_rec (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt         (evt),
    .evt_addr    (evt_addr),
    .chk_vld     (chk_vld),
    .exc_ack     (exc_ack),
    .pend_code   (pend_code),
    .pend_addr   (pend_addr),
    .pend_ilen   (pend_ilen),
    .nullify_req (nullify_req),
    .exc_req     (exc_req),
    .exc_ilen    (exc_ilen)
  );

  AST_BR_DISABLED_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (br_vld && !fe_vld && !ctl_word[CTL_BR_EN] && !exc_ack) |=> $stable(pend_code)); // R4
  AST_FETCH_ADDR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.vld && fe_vld && cmp_hit[1] && ctl_word[CTL_FE_EN]) |=> (pend_addr == $past(fe_addr))); // R11
endmodule

// File: tb/pem_monitor_tb_top.sv
`timescale 1ns/1ps
module pem_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  ctl_word;
  logic [63:0] win_lo, win_hi;
  logic [1:0]  space_id;
  logic        br_vld;
  logic [63:0] br_from, br_to;
  logic [1:0]  br_ilen;
  logic        fe_vld;
  logic [63:0] fe_addr;
  logic [1:0]  fe_ilen;
  logic        chk_vld, exc_ack;
  logic [7:0]  pend_code;
  logic [63:0] pend_addr;
  logic [1:0]  pend_ilen;
  logic        nullify_req, exc_req;
  logic [1:0]  exc_ilen;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0]  m_code;
  logic [63:0] m_addr;
  logic [1:0]  m_ilen;
  logic        m_null, m_exc;
  logic [1:0]  m_eilen;

  always #4 clk = ~clk;

  pem_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word), .win_lo(win_lo), .win_hi(win_hi),
    .space_id(space_id), .br_vld(br_vld), .br_from(br_from), .br_to(br_to),
    .br_ilen(br_ilen), .fe_vld(fe_vld), .fe_addr(fe_addr), .fe_ilen(fe_ilen),
    .chk_vld(chk_vld), .exc_ack(exc_ack), .pend_code(pend_code), .pend_addr(pend_addr),
    .pend_ilen(pend_ilen), .nullify_req(nullify_req), .exc_req(exc_req), .exc_ilen(exc_ilen)
  );

  function automatic bit in_win(logic [63:0] lo, logic [63:0] hi, logic [63:0] a);
    if (lo <= hi) return (a >= lo) && (a <= hi);
    return (a >= lo) || (a <= hi);
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "pend_code", 64'(pend_code), 64'(m_code));
    chk(tag, "pend_addr", pend_addr, m_addr);
    chk(tag, "pend_ilen", 64'(pend_ilen), 64'(m_ilen));
    chk(tag, "nullify_req", 64'(nullify_req), 64'(m_null));
    chk(tag, "exc_req", 64'(exc_req), 64'(m_exc));
    chk(tag, "exc_ilen", 64'(exc_ilen), 64'(m_eilen));
  endtask

  task automatic model_reset();
    m_code = '0; m_addr = '0; m_ilen = '0; m_null = 0; m_exc = 0; m_eilen = '0;
  endtask

  task automatic model_step();
    bit brq, feq, nul, hit;
    brq = br_vld && ctl_word[0] && (!ctl_word[2] || in_win(win_lo, win_hi, br_to));
    feq = fe_vld && ctl_word[1] && in_win(win_lo, win_hi, fe_addr);
    nul = feq && ctl_word[3];
    hit = chk_vld && (m_code != 0);
    m_exc   = nul || hit;
    m_eilen = nul ? fe_ilen : (hit ? m_ilen : 2'd0);
    m_null  = nul;
    if (feq) begin
      m_code = 8'h40 | 8'(space_id) | (nul ? 8'h04 : 8'h00) | (brq ? 8'h80 : 8'h00);
      m_addr = fe_addr; m_ilen = fe_ilen;
    end else if (brq) begin
      m_code = 8'h80 | 8'(space_id); m_addr = br_from; m_ilen = br_ilen;
    end else if (exc_ack) begin
      m_code = '0; m_addr = '0; m_ilen = '0;
    end
  endtask

  task automatic idle_in();
    br_vld = 0; fe_vld = 0; chk_vld = 0; exc_ack = 0;
    br_from = '0; br_to = '0; br_ilen = '0; fe_addr = '0; fe_ilen = '0;
  endtask

  task automatic step(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    idle_in();
  endtask

  task automatic fetch(logic [63:0] a, logic [1:0] l, string tag);
    fe_vld = 1; fe_addr = a; fe_ilen = l; step(tag);
  endtask

  task automatic branch(logic [63:0] f, logic [63:0] t, logic [1:0] l, string tag);
    br_vld = 1; br_from = f; br_to = t; br_ilen = l; step(tag);
  endtask

  task automatic ack(string tag);
    exc_ack = 1; step(tag);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle_in();
    ctl_word = 4'h0; win_lo = 64'h1000; win_hi = 64'h2000; space_id = 2'd0;
    rst_n = 0;
    model_reset();
    @(negedge clk); @(negedge clk);
    compare("R1");
    rst_n = 1;
    step("R1");

    // R2: inclusive non-wrapping window
    ctl_word = 4'b0010; space_id = 2'd1;
    fetch(64'h1000, 2'd1, "R2");
    ack("R10");
    fetch(64'h2000, 2'd2, "R2");
    ack("R10");
    fetch(64'h0FFF, 2'd1, "R2");
    fetch(64'h2001, 2'd1, "R2");
    fetch(64'h1800, 2'd3, "R7");

    // R7: fetch enable clear
    ack("R10");
    ctl_word = 4'b0000;
    fetch(64'h1800, 2'd1, "R7");

    // R3: wrapping window
    ctl_word = 4'b0010; win_lo = 64'hFFFF_FFFF_FFFF_F000; win_hi = 64'h10;
    fetch(64'hFFFF_FFFF_FFFF_FFFF, 2'd2, "R3");
    fetch(64'h10, 2'd1, "R3");
    ack("R10");
    fetch(64'h11, 2'd1, "R3");
    fetch(64'h8000, 2'd1, "R3");
    fetch(64'hFFFF_FFFF_FFFF_F000, 2'd3, "R3");
    ack("R10");

    // R4, R5, R6: branches
    win_lo = 64'h4000; win_hi = 64'h4FFF; space_id = 2'd2;
    ctl_word = 4'b0000;
    branch(64'h100, 64'h4100, 2'd1, "R4");
    ctl_word = 4'b0001;
    branch(64'h200, 64'h9000, 2'd2, "R5");
    ack("R10");
    ctl_word = 4'b0101;
    branch(64'h300, 64'h9000, 2'd2, "R5");
    branch(64'h304, 64'h4FFF, 2'd3, "R6");
    branch(64'h308, 64'h4000, 2'd1, "R12");

    // R9: check strobe with pending and empty record
    chk_vld = 1; step("R9");
    step("R9");
    ack("R10");
    chk_vld = 1; step("R9");

    // R10: ack and event together
    branch(64'h400, 64'h4200, 2'd2, "R6");
    exc_ack = 1; br_vld = 1; br_from = 64'h500; br_to = 64'h4300; br_ilen = 2'd3;
    step("R10");

    // R8: nullifying fetch, also with a check in the same cycle
    ctl_word = 4'b1010; space_id = 2'd3;
    fetch(64'h4010, 2'd2, "R8");
    step("R8");
    chk_vld = 1; fe_vld = 1; fe_addr = 64'h4020; fe_ilen = 2'd3; step("R8");
    ack("R10");

    // R11: branch and fetch together
    ctl_word = 4'b0011; space_id = 2'd1;
    br_vld = 1; br_from = 64'h600; br_to = 64'h700; br_ilen = 2'd1;
    fe_vld = 1; fe_addr = 64'h4040; fe_ilen = 2'd2; step("R11");
    br_vld = 1; br_from = 64'h610; br_to = 64'h700; br_ilen = 2'd1;
    fe_vld = 1; fe_addr = 64'h9999; fe_ilen = 2'd2; step("R11");

    // R1: asynchronous reset with a record pending
    @(posedge clk); #1;
    rst_n = 0; model_reset();
    #2;
    compare("R1");
    @(negedge clk);
    rst_n = 1;
    step("R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule